// File: doc/BRIEF.md
# Multimode Serial Receiver with Interrupt Flags

This block is the receive half of a microcontroller-style asynchronous serial port, together with its interrupt flag logic. An external baud generator supplies a tick at sixteen times the bit rate. On each bit the receiver takes three samples around the middle of the bit and keeps the 2-of-3 majority. It assembles either a 10-bit frame (start bit, eight data bits, stop bit) or an 11-bit frame (start bit, nine data bits, stop bit). It then hands the byte and the ninth bit to a small register set.

Three sticky flags hold the state of the port: receive complete, transmit complete and framing error. The transmit flag is set by a pulse from a separate transmitter. The receive and transmit flags are merged into one interrupt request, which passes only when both a serial enable and a global enable are set. In the 9-bit modes a multiprocessor control can accept only address frames (ninth bit high) whose byte matches a masked station address or a masked broadcast address. Both the address and the mask reset to zero, so every frame is accepted until software sets them. A framing-check control decides whether the receive flag is raised during the ninth bit or during the stop bit, and whether a low stop bit sets the framing error flag.

Top module: `serrx_top`

## Requirements
- R1: After reset, flag_ri, flag_ti, flag_fe and irq are 0, rx_data and rx_bit9 are 0, and all control bits are 0.
- R2: Register writes use wr_addr 0 for control, 1 for the station address, 2 for the address mask and 3 for flag clears. The control bits are bit0 nine-bit mode, bit1 receive enable, bit2 multiprocessor enable, bit3 framing check enable, bit4 serial interrupt enable and bit5 global interrupt enable. A write of 1 to address 3 clears RI with bit0, TI with bit1 and FE with bit2.
- R3: A start bit begins on a falling edge of the line. If the majority of the mid-bit samples of that start bit is high, the receiver returns to idle and nothing is received.
- R4: In 8-bit mode, data is taken LSB first, and flag_ri is raised during the stop bit (never before it), whatever the framing check enable.
- R5: In 9-bit mode, with framing check disabled, flag_ri is raised during the ninth data bit. With it enabled, flag_ri is raised during the stop bit. rx_bit9 holds the ninth data bit.
- R6: With framing check enabled, a stop bit whose majority sample is low sets flag_fe. With it disabled, flag_fe is never set.
- R7: irq is 1 exactly when (flag_ri OR flag_ti) AND the serial interrupt enable AND the global interrupt enable.
- R8: If flag_ri is still set when a frame completes, that frame's data is discarded, rx_data and rx_bit9 keep their values, and reception continues with the next frame.
- R9: In 9-bit mode with multiprocessor enable set, a frame raises flag_ri only if D8=1 and the byte either matches the address in every bit where the mask is 1, or has a 1 in every bit where (address OR mask) is 1.
- R10: With the reset address and mask (both 0x00), every 9-bit frame with D8=1 passes the multiprocessor filter, and every one with D8=0 is rejected.
- R11: flag_ri, flag_ti and flag_fe never clear by themselves. They stay set until the matching clear bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W | Register write data |
| tx_done | input | 1 | Pulse from the transmitter; sets the transmit flag |
| rx_data | output | DATA_W | Last accepted byte |
| rx_bit9 | output | 1 | Ninth data bit of the last accepted frame |
| flag_ri | output | 1 | Receive-complete flag |
| flag_ti | output | 1 | Transmit-complete flag |
| flag_fe | output | 1 | Framing-error flag |
| irq | output | 1 | Combined serial interrupt request |

## Verification
The point in the frame where the receive flag rises is the hardest thing to pin down from the ports, because at the end of the frame a flag raised in the ninth bit looks the same as one raised in the stop bit. The bench drives frames bit by bit in step with the oversampling tick. It reads the flag thirteen ticks into the last data bit, which is past the middle-sample decision but before the stop bit starts. The multiprocessor filter is swept over a set of bytes against a non-trivial address and mask, and the expected acceptance is worked out arithmetically for each byte.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic glb_ie;
        logic ser_ie;
        logic fe_en;
        logic mp_en;
        logic rx_en;
        logic mode9;
    } ctrl_t;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_ADDR = 2'd1;
    localparam logic [1:0] RA_MASK = 2'd2;
    localparam logic [1:0] RA_CLR  = 2'd3;

endpackage

// File: rtl/serrx_bitvote.sv
module serrx_bitvote #(
    parameter int unsigned OS_RATE = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         os_tick,
    input  logic                         rxd,
    input  logic                         active,
    input  logic [$clog2(OS_RATE)-1:0]   cur_idx,
    output logic                         fall_evt,
    output logic                         vote_stb,
    output logic                         vote
);
    localparam int unsigned CW  = $clog2(OS_RATE);
    localparam int unsigned MID = OS_RATE / 2;

    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
        logic       s_lo;
        logic       s_mid;
    } vote_q_t;

    vote_q_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd};
        if (os_tick) begin
            d.prev = q.sync[1];
            if (active && cur_idx == CW'(MID - 1)) d.s_lo  = q.sync[1];
            if (active && cur_idx == CW'(MID))     d.s_mid = q.sync[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sync: 2'b11, prev: 1'b1, s_lo: 1'b1, s_mid: 1'b1};
        else        q <= d;
    end

    // falling edge between two consecutive ticks
    assign fall_evt = os_tick & q.prev & ~q.sync[1];
    assign vote_stb = os_tick & active & (cur_idx == CW'(MID + 1));
    assign vote     = (q.s_lo & q.s_mid) | (q.s_lo & q.sync[1]) | (q.s_mid & q.sync[1]);

endmodule

// File: rtl/serrx_addr_match.sv
module serrx_addr_match #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] station,
    input  logic [DW-1:0] mask,
    output logic          hit
);
    logic [DW-1:0] given_ok;
    logic [DW-1:0] bcast_ok;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        // station pattern: only bits selected by the mask must agree
        assign given_ok[i] = ~mask[i] | (rx_byte[i] == station[i]);
        // broadcast pattern: every 1 in (station | mask) must be received as 1
        assign bcast_ok[i] = ~(station[i] | mask[i]) | rx_byte[i];
    end

    assign hit = (&given_ok) | (&bcast_ok);

endmodule

// File: rtl/serrx_framer.sv
module serrx_framer
    import serrx_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned OS_RATE = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        os_tick,
    input  logic                        rx_en,
    input  logic                        mode9,
    input  logic                        fe_en,
    input  logic                        fall_evt,
    input  logic                        vote_stb,
    input  logic                        vote,
    output logic                        active,
    output logic [$clog2(OS_RATE)-1:0]  cur_idx,
    output logic                        cmp_stb,
    output logic [DW-1:0]               frm_data,
    output logic                        frm_b9,
    output logic                        frm_mode9,
    output logic                        frm_fe_en,
    output logic                        fe_stb
);
    localparam int unsigned CW = $clog2(OS_RATE);
    localparam int unsigned BW = $clog2(DW + 1);

    typedef struct packed {
        rx_state_t      st;
        logic [CW-1:0]  tick;
        logic [BW-1:0]  bitn;
        logic [DW-1:0]  shift;
        logic           b9;
        logic           m9;
        logic           fe_chk;
    } frm_q_t;

    frm_q_t q, d;

    assign cur_idx = q.tick + CW'(1);
    assign active  = (q.st != ST_IDLE);

    always_comb begin
        d       = q;
        cmp_stb = 1'b0;
        fe_stb  = 1'b0;
        if (active && os_tick) d.tick = cur_idx;
        unique case (q.st)
            ST_IDLE: begin
                if (fall_evt && rx_en) begin
                    d.st     = ST_START;
                    d.tick   = '0;
                    d.m9     = mode9;
                    d.fe_chk = fe_en;
                    d.b9     = 1'b0;
                end
            end
            ST_START: begin
                if (vote_stb) begin
                    if (vote) d.st = ST_IDLE;
                    else begin
                        d.st   = ST_DATA;
                        d.bitn = '0;
                    end
                end
            end
            ST_DATA: begin
                if (vote_stb) begin
                    d.shift = {vote, q.shift[DW-1:1]};
                    d.bitn  = q.bitn + BW'(1);
                    if (q.bitn == BW'(DW - 1)) d.st = q.m9 ? ST_NINTH : ST_STOP;
                end
            end
            ST_NINTH: begin
                if (vote_stb) begin
                    d.b9 = vote;
                    d.st = ST_STOP;
                    if (!q.fe_chk) cmp_stb = 1'b1;
                end
            end
            ST_STOP: begin
                if (vote_stb) begin
                    d.st = ST_IDLE;
                    if (q.fe_chk && !vote) fe_stb = 1'b1;
                    if (!q.m9 || q.fe_chk) cmp_stb = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, tick: '0, bitn: '0, shift: '0,
                           b9: 1'b0, m9: 1'b0, fe_chk: 1'b0};
        else        q <= d;
    end

    assign frm_data  = q.shift;
    assign frm_b9    = (q.st == ST_NINTH) ? vote : q.b9;
    assign frm_mode9 = q.m9;
    assign frm_fe_en = q.fe_chk;

endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              flag_ri,
    output logic              flag_ti,
    output logic              flag_fe,
    output logic              irq
);
    localparam int unsigned CW = $clog2(OS_RATE);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] station;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] data;
        logic              b9;
        logic              ri;
        logic              ti;
        logic              fe;
    } top_q_t;

    top_q_t q, d;

    logic          fall_evt, vote_stb, vote, active;
    logic [CW-1:0] cur_idx;
    logic          cmp_stb, frm_b9, frm_mode9, frm_fe_en, fe_stb, addr_hit, take;
    logic [DATA_W-1:0] frm_data;

    serrx_bitvote #(.OS_RATE(OS_RATE)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .rxd      (rxd),
        .active   (active),
        .cur_idx  (cur_idx),
        .fall_evt (fall_evt),
        .vote_stb (vote_stb),
        .vote     (vote)
    );

    serrx_framer #(.DW(DATA_W), .OS_RATE(OS_RATE)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_en     (q.ctrl.rx_en),
        .mode9     (q.ctrl.mode9),
        .fe_en     (q.ctrl.fe_en),
        .fall_evt  (fall_evt),
        .vote_stb  (vote_stb),
        .vote      (vote),
        .active    (active),
        .cur_idx   (cur_idx),
        .cmp_stb   (cmp_stb),
        .frm_data  (frm_data),
        .frm_b9    (frm_b9),
        .frm_mode9 (frm_mode9),
        .frm_fe_en (frm_fe_en),
        .fe_stb    (fe_stb)
    );

    serrx_addr_match #(.DW(DATA_W)) u_match (
        .rx_byte (frm_data),
        .station (q.station),
        .mask    (q.mask),
        .hit     (addr_hit)
    );

    always_comb begin
        d    = q;
        take = cmp_stb && !q.ri &&
               (!(frm_mode9 && q.ctrl.mp_en) || (frm_b9 && addr_hit));
        if (wr_en) begin
            unique case (wr_addr)
                RA_CTRL: begin
                    d.ctrl.mode9  = wr_data[0];
                    d.ctrl.rx_en  = wr_data[1];
                    d.ctrl.mp_en  = wr_data[2];
                    d.ctrl.fe_en  = wr_data[3];
                    d.ctrl.ser_ie = wr_data[4];
                    d.ctrl.glb_ie = wr_data[5];
                end
                RA_ADDR: d.station = wr_data;
                RA_MASK: d.mask    = wr_data;
                RA_CLR: begin
                    if (wr_data[0]) d.ri = 1'b0;
                    if (wr_data[1]) d.ti = 1'b0;
                    if (wr_data[2]) d.fe = 1'b0;
                end
                default: ;
            endcase
        end
        // hardware events win over a clear in the same cycle
        if (take) begin
            d.ri   = 1'b1;
            d.data = frm_data;
            d.b9   = frm_b9;
        end
        if (tx_done) d.ti = 1'b1;
        if (fe_stb)  d.fe = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data = q.data;
    assign rx_bit9 = q.b9;
    assign flag_ri = q.ri;
    assign flag_ti = q.ti;
    assign flag_fe = q.fe;
    assign irq     = (q.ri | q.ti) & q.ctrl.ser_ie & q.ctrl.glb_ie;

endmodule

// File: rtl/serrx_chk.sv
module serrx_chk
    import serrx_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          flag_ri,
    input logic          flag_ti,
    input logic          flag_fe,
    input logic          irq,
    input logic [DW-1:0] rx_data,
    input logic          rx_bit9,
    input logic          fe_en_frm
);
    // R11
    ri_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ri && !(wr_en && wr_addr == RA_CLR && wr_data[0]) |=> flag_ri);

    // R11
    ti_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ti && !(wr_en && wr_addr == RA_CLR && wr_data[1]) |=> flag_ti);

    // R11
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_fe && !(wr_en && wr_addr == RA_CLR && wr_data[2]) |=> flag_fe);

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_ri || flag_ti));

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ri |=> ($stable(rx_data) && $stable(rx_bit9)));

    // R6
    fe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_fe) |-> $past(fe_en_frm));

endmodule

bind serrx_top serrx_chk #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flag_ri   (flag_ri),
    .flag_ti   (flag_ti),
    .flag_fe   (flag_fe),
    .irq       (irq),
    .rx_data   (rx_data),
    .rx_bit9   (rx_bit9),
    .fe_en_frm (frm_fe_en)
);

// File: tb/serrx_top_tb.sv
module serrx_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tx_done = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, flag_ri, flag_ti, flag_fe, irq;

    int n_chk = 0;
    int n_bad = 0;
    int tdiv = 0;

    serrx_top u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tx_done(tx_done),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .flag_ri(flag_ri),
        .flag_ti(flag_ti), .flag_fe(flag_fe), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
        os_tick <= (tdiv == 3);
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input bit m9, input bit mp, input bit fe,
                                       input bit es, input bit ea);
        return {2'b00, ea, es, fe, mp, 1'b1, m9};
    endfunction

    task automatic send_frame(input bit m9, input logic [7:0] b, input bit d8,
                              input bit stopv, output logic ri_early);
        rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            if (!m9 && i == 7) begin
                wait_ticks(13); ri_early = flag_ri; wait_ticks(3);
            end else wait_ticks(16);
        end
        if (m9) begin
            rxd = d8;
            wait_ticks(13); ri_early = flag_ri; wait_ticks(3);
        end
        rxd = stopv;
        wait_ticks(16);
        rxd = 1'b1;
        wait_ticks(4);
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic early;
        logic [7:0] b, last;
        bit d8, exp_acc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ri", flag_ri, 0);
        check("R1 ti", flag_ti, 0);
        check("R1 fe", flag_fe, 0);
        check("R1 irq", irq, 0);
        check("R1 data", rx_data, 0);

        // R2 R4: 8-bit sweep, framing check off and on
        for (int k = 0; k < 8; k++) begin
            b = 8'(k * 37 + 5);
            wr(2'd0, ctl(0, 0, k[0], 0, 0));
            send_frame(0, b, 0, 1, early);
            check("R4 no RI before stop", early, 0);
            check("R2 RI set", flag_ri, 1);
            check("R2 data LSB first", rx_data, b);
            wr(2'd3, 8'h01);
            check("R11 RI cleared by write", flag_ri, 0);
        end

        // R5: 9-bit, RI point depends on framing check
        for (int k = 0; k < 8; k++) begin
            b = 8'(k * 71 + 3);
            d8 = k[1];
            wr(2'd0, ctl(1, 0, k[0], 0, 0));
            send_frame(1, b, d8, 1, early);
            check("R5 RI point", early, k[0] ? 0 : 1);
            check("R5 RI set", flag_ri, 1);
            check("R5 data", rx_data, b);
            check("R5 bit9", rx_bit9, d8);
            wr(2'd3, 8'h01);
        end

        // R6: framing error
        wr(2'd0, ctl(0, 0, 1, 0, 0));
        send_frame(0, 8'hA5, 0, 0, early);
        check("R6 FE set on low stop", flag_fe, 1);
        wait_ticks(40);
        check("R11 FE persists", flag_fe, 1);
        wr(2'd3, 8'h05);
        check("R11 FE cleared", flag_fe, 0);
        wr(2'd0, ctl(1, 0, 0, 0, 0));
        send_frame(1, 8'h5A, 1, 0, early);
        check("R6 FE not set when disabled", flag_fe, 0);
        wr(2'd3, 8'h01);

        // R3: short low glitch is not a start bit
        wr(2'd0, ctl(0, 0, 0, 0, 0));
        last = rx_data;
        rxd = 1'b0; wait_ticks(4); rxd = 1'b1; wait_ticks(24);
        check("R3 glitch no RI", flag_ri, 0);
        check("R3 glitch data kept", rx_data, last);
        send_frame(0, 8'h6E, 0, 1, early);
        check("R3 next frame ok", rx_data, 8'h6E);

        // R8: overrun keeps old data, reception resumes
        send_frame(0, 8'hC3, 0, 1, early);
        check("R8 data kept", rx_data, 8'h6E);
        check("R8 RI stays", flag_ri, 1);
        wr(2'd3, 8'h01);
        send_frame(0, 8'h99, 0, 1, early);
        check("R8 resumes", rx_data, 8'h99);
        wr(2'd3, 8'h01);

        // R10: reset address and mask accept any address frame
        wr(2'd0, ctl(1, 1, 0, 0, 0));
        send_frame(1, 8'h77, 1, 1, early);
        check("R10 D8=1 accepted", flag_ri, 1);
        check("R10 data", rx_data, 8'h77);
        wr(2'd3, 8'h01);
        send_frame(1, 8'h12, 0, 1, early);
        check("R10 D8=0 rejected", flag_ri, 0);
        check("R10 data kept", rx_data, 8'h77);

        // R9: masked address sweep, station 0x5A mask 0x0F
        wr(2'd1, 8'h5A);
        wr(2'd2, 8'h0F);
        for (int k = 0; k < 18; k++) begin
            if (k == 16) b = 8'hFF;
            else if (k == 17) b = 8'h5F;
            else b = 8'(k * 53 + 10);
            d8 = (k % 5) != 4;
            exp_acc = d8 && ((((b ^ 8'h5A) & 8'h0F) == 0) ||
                             ((b & 8'h5F) == 8'h5F));
            last = rx_data;
            send_frame(1, b, d8, 1, early);
            check("R9 accept", flag_ri, exp_acc);
            check("R9 data", rx_data, exp_acc ? b : last);
            wr(2'd3, 8'h01);
        end

        // R7: interrupt combination
        @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, ctl(0, 0, 0, k[0], k[1]));
            check("R7 irq from TI", irq, (k == 3) ? 1 : 0);
        end
        wait_ticks(20);
        check("R11 TI persists", flag_ti, 1);
        wr(2'd3, 8'h02);
        check("R2 TI cleared by bit1", flag_ti, 0);
        check("R7 irq drops", irq, 0);
        send_frame(0, 8'h3C, 0, 1, early);
        check("R7 irq from RI", irq, 1);
        wr(2'd3, 8'h01);
        check("R7 irq idle", irq, 0);

        finish_up();
    end

endmodule